// File: doc/BRIEF.md
# Ten-Phase Ring Sequencer

This block is a free-running timing generator for a digit-serial BCD arithmetic unit. A one-hot token moves through a ring of ten stages, one stage per clock. The ring is split into two cascaded sections of five stages each. The token leaving the last stage of the first section enters the head of the second section. The token leaving the tail of the second section wraps back to the head of the first.

The block drives several outputs from this ring:

- Every stage drives a one-clock phase strobe.
- The five stages of the second section double as successive digit-select strobes that read stored digits out one at a time.
- The head of the second section gives a re-clock strobe for the adder's carry-in path.
- The tail of the second section gives a reference tick once per ten clocks.
- A pair of set/clear toggles turns the tokens that enter each section head into two complementary square waves. Each wave has a ten-clock period with five clocks per half. They enable the first and the second accumulation half-cycle.

A ring state that is not one-hot is replaced by the single-token state on the next clock, so the sequencer cannot lock up after an upset.

Top module: `ring_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `phase_o` equal to 10'b0000000001 (stage 0), `en_first_o` high and `en_second_o` low.
- R2: With `rst` low, the active phase moves from stage k to stage k+1 on each clock, and from stage 9 back to stage 0.
- R3: Exactly one bit of `phase_o` is high in every cycle after reset.
- R4: `digit_sel_o` bit j is high exactly when stage 5+j is active (j = 0..4), and is zero while stages 0..4 are active.
- R5: `en_first_o` is high exactly while stages 0..4 are active, and `en_second_o` is high exactly while stages 5..9 are active. The two are always complementary.
- R6: `ref_tap_o` is high only while stage 9 is active, giving one pulse per ten clocks.
- R7: `carry_strobe_o` is high only while stage 5 is active.
- R8: A reset applied at any point of the sequence returns the block to the R1 state on the next clock, and the sequence then resumes from stage 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_o | output | 10 | One-hot phase strobes, bit k = stage k |
| digit_sel_o | output | 5 | Digit-select strobes from the second section |
| carry_strobe_o | output | 1 | Carry-in re-clock strobe (stage 5) |
| en_first_o | output | 1 | First accumulation half-cycle enable |
| en_second_o | output | 1 | Second accumulation half-cycle enable |
| ref_tap_o | output | 1 | Reference tick (stage 9) |

## Verification
The checker watches several properties on every cycle:

- the one-hot property of the phase strobes;
- the one-position rotation from each cycle to the next;
- the complementarity of the two enables, and the match between the first enable and the first-section window;
- the ordering of the carry strobe and the reference tick relative to their neighbouring stages.

The bench's scenarios show the exact reset state, the recovery to stage 0 after a reset landed at random points in the sequence, and the exact alignment of every strobe against a reference phase count over long random runs. Recovery from a corrupted ring state cannot be reached through the ports, so only the one-hot property checked each cycle covers it.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;

    localparam int unsigned SECT_LEN_DEF  = 5;
    localparam int unsigned NUM_SECT      = 2;
    localparam int unsigned MAX_RING_BITS = 32;

    typedef struct packed {
        logic first;
        logic second;
    } half_en_t;

    localparam half_en_t HALF_EN_RESET = '{first: 1'b1, second: 1'b0};

    // True when exactly one of the low 'width' bits is set.
    function automatic logic ring_is_onehot(input logic [MAX_RING_BITS-1:0] v,
                                            input int unsigned width);
        int unsigned ones;
        ones = 0;
        for (int unsigned i = 0; i < MAX_RING_BITS; i++) begin
            if (i < width && v[i]) ones++;
        end
        return (ones == 1);
    endfunction

endpackage

// File: rtl/ring_section.sv
module ring_section #(
    parameter int unsigned LEN       = 5,
    parameter bit          LOAD_HEAD = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           recover,
    input  logic           feed_in,
    output logic [LEN-1:0] stage_q
);
    localparam logic [LEN-1:0] LOAD_VAL = LOAD_HEAD ? LEN'(1) : '0;

    always_ff @(posedge clk) begin
        if (rst || recover) begin
            stage_q <= LOAD_VAL;
        end else begin
            stage_q <= {stage_q[LEN-2:0], feed_in};
        end
    end
endmodule

// File: rtl/half_toggle.sv
module half_toggle
    import ring_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_p,
    input  logic     clr_p,
    output half_en_t en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= HALF_EN_RESET;
        end else begin
            if (set_p)      en_q.first <= 1'b1;
            else if (clr_p) en_q.first <= 1'b0;
            if (clr_p)      en_q.second <= 1'b1;
            else if (set_p) en_q.second <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_sequencer.sv
module ring_sequencer
    import ring_seq_pkg::*;
#(
    parameter int unsigned SECT_LEN = SECT_LEN_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    output logic [NUM_SECT*SECT_LEN-1:0] phase_o,
    output logic [SECT_LEN-1:0]          digit_sel_o,
    output logic                         carry_strobe_o,
    output logic                         en_first_o,
    output logic                         en_second_o,
    output logic                         ref_tap_o
);
    localparam int unsigned RING_LEN = NUM_SECT * SECT_LEN;
    localparam int unsigned TAIL_IDX = RING_LEN - 1;
    localparam int unsigned SEC2_HEAD = SECT_LEN;

    logic [RING_LEN-1:0] ring_state;
    logic                recover;
    half_en_t            half_en;

    assign recover = !ring_is_onehot(MAX_RING_BITS'(ring_state), RING_LEN);

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        localparam int unsigned FEED_IDX = (s == 0) ? TAIL_IDX : s * SECT_LEN - 1;
        logic [SECT_LEN-1:0] sec_q;

        ring_section #(
            .LEN      (SECT_LEN),
            .LOAD_HEAD(s == 0)
        ) sect_i (
            .clk    (clk),
            .rst    (rst),
            .recover(recover),
            .feed_in(ring_state[FEED_IDX]),
            .stage_q(sec_q)
        );

        assign ring_state[s*SECT_LEN +: SECT_LEN] = sec_q;
    end

    // Tokens about to enter each section head flip the toggles, so each
    // enable lines up with its own section's five stages.
    half_toggle tog_i (
        .clk  (clk),
        .rst  (rst),
        .set_p(ring_state[TAIL_IDX]),
        .clr_p(ring_state[SEC2_HEAD-1]),
        .en_q (half_en)
    );

    assign phase_o        = ring_state;
    assign digit_sel_o    = ring_state[SEC2_HEAD +: SECT_LEN];
    assign carry_strobe_o = ring_state[SEC2_HEAD];
    assign ref_tap_o      = ring_state[TAIL_IDX];
    assign en_first_o     = half_en.first;
    assign en_second_o    = half_en.second;
endmodule

// File: rtl/ring_seq_chk.sv
module ring_seq_chk
    import ring_seq_pkg::*;
#(
    parameter int unsigned SECT_LEN = SECT_LEN_DEF
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_SECT*SECT_LEN-1:0] phase_o,
    input logic [SECT_LEN-1:0]          digit_sel_o,
    input logic                         carry_strobe_o,
    input logic                         en_first_o,
    input logic                         en_second_o,
    input logic                         ref_tap_o
);
    localparam int unsigned N = NUM_SECT * SECT_LEN;

    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase_o));

    p_rotate_r2: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(phase_o) |=> phase_o == {$past(phase_o[N-2:0]), $past(phase_o[N-1])});

    p_digit_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_sel_o) && ((digit_sel_o != '0) == en_second_o));

    p_complement_r5: assert property (@(posedge clk) disable iff (rst)
        en_first_o != en_second_o);

    p_first_window_r5: assert property (@(posedge clk) disable iff (rst)
        en_first_o == (phase_o[SECT_LEN-1:0] != '0));

    p_ref_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        ref_tap_o |=> phase_o[0]);

    p_carry_order_r7: assert property (@(posedge clk) disable iff (rst)
        carry_strobe_o |-> $past(phase_o[SECT_LEN-1]));

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (phase_o == N'(1)) && en_first_o && !en_second_o);
endmodule

bind ring_sequencer ring_seq_chk #(.SECT_LEN(SECT_LEN)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .phase_o       (phase_o),
    .digit_sel_o   (digit_sel_o),
    .carry_strobe_o(carry_strobe_o),
    .en_first_o    (en_first_o),
    .en_second_o   (en_second_o),
    .ref_tap_o     (ref_tap_o)
);

// File: tb/ring_sequencer_tb_top.sv
module ring_sequencer_tb_top;
    localparam int N = 10;
    localparam int S = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] phase_o;
    logic [S-1:0] digit_sel_o;
    logic carry_strobe_o, en_first_o, en_second_o, ref_tap_o;

    int checks = 0;
    int failures = 0;
    int p = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ring_sequencer dut_i (
        .clk(clk), .rst(rst), .phase_o(phase_o), .digit_sel_o(digit_sel_o),
        .carry_strobe_o(carry_strobe_o), .en_first_o(en_first_o),
        .en_second_o(en_second_o), .ref_tap_o(ref_tap_o)
    );

    function automatic logic [N-1:0] exp_phase(int k);
        return N'(1) << k;
    endfunction

    function automatic logic [S-1:0] exp_digit(int k);
        return (k >= S) ? (S'(1) << (k - S)) : '0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s phase=%0d actual=%0h expected=%0h", req, p, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R2 phase"}, 32'(phase_o), 32'(exp_phase(p)));
        chk("R3 onehot", 32'($countones(phase_o)), 32'd1);
        chk("R4 digit", 32'(digit_sel_o), 32'(exp_digit(p)));
        chk("R5 first", 32'(en_first_o), 32'(p < S));
        chk("R5 second", 32'(en_second_o), 32'(p >= S));
        chk("R6 ref", 32'(ref_tap_o), 32'(p == N - 1));
        chk("R7 carry", 32'(carry_strobe_o), 32'(p == S));
    endtask

    task automatic step(bit r);
        rst = r;
        @(posedge clk);
        p = r ? 0 : (p + 1) % N;
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1234);
        @(negedge clk);
        step(1'b1);
        step(1'b1);
        // R1: reset state
        chk("R1 phase", 32'(phase_o), 32'd1);
        chk("R1 en_first", 32'(en_first_o), 32'd1);
        chk("R1 en_second", 32'(en_second_o), 32'd0);
        // Two full laps, directed
        for (int i = 0; i < 2 * N; i++) begin
            step(1'b0);
            check_all("lap");
        end
        // Directed R8: reset landing on the last stage
        while (p != N - 1) step(1'b0);
        step(1'b1);
        chk("R8 after reset at tail", 32'(phase_o), 32'd1);
        check_all("R8");
        // Random run with occasional resets
        for (int i = 0; i < 4000; i++) begin
            bit r;
            r = ($urandom_range(0, 47) == 0);
            step(r);
            if (r) chk("R8 random reset", 32'(phase_o), 32'd1);
            check_all(r ? "R8" : "rnd");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule